// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Thresholds

This block is a first-in first-out buffer between two unrelated clock domains. Words enter on the write clock and leave on the read clock, and neither clock's frequency is tied to the other. Five status outputs describe the buffer. Empty and almost-empty are produced in the read domain. Full, half-full and almost-full are produced in the write domain. Each domain learns where the other side's pointer is from a Gray-coded copy that passes through a two-flop synchronizer.

The almost-empty threshold is counted up from the empty boundary, and the almost-full threshold is counted down from the full boundary. Each threshold has its own register. While the master reset is held, one of eight built-in threshold pairs is chosen by three select inputs. After reset, either threshold can be rewritten bit by bit through a serial port on the write clock. A partial reset empties the buffer and clears the read register but keeps whatever thresholds are loaded. A master reset returns everything to its initial state. Driving the output enable low releases the read-data bus to high impedance. The preset table needs `ADDR_W` of at least 4.

Top module: `dc_flag_fifo`

## Requirements
- R1: After master reset: `empty`=1, `almost_empty`=1, `full`=0, `half_full`=0, `almost_full`=0, and `rd_data`=0 while `oe`=1.
- R2: Words are read out in the order they were written. `rd_data` takes the new word on the read-clock edge that accepts `rd_en`.
- R3: `full` is 1 exactly when 2^ADDR_W words are held. A write while full is dropped and does not disturb the stored sequence.
- R4: A read while empty is ignored. `rd_data` keeps its previous value and later traffic is unaffected.
- R5: `half_full` is 1 when occupancy is greater than 2^(ADDR_W-1).
- R6: `almost_empty` is 1 when occupancy is less than or equal to the almost-empty offset.
- R7: `almost_full` is 1 when free space (2^ADDR_W minus occupancy) is less than or equal to the almost-full offset.
- R8: While `mrst_n` is low, the value s = {`ser_ld`, `preset_sel[1]`, `preset_sel[0]`} (so `ser_ld` is the MSB) is sampled on the write clock. It loads almost-empty offset s+1 and almost-full offset 8-s.
- R9: On each write-clock edge with `ser_en`=1 and `ser_ld`=1, one bit of `ser_in` is shifted in, LSB first. The first ADDR_W bits form the almost-empty offset and the next ADDR_W bits form the almost-full offset. Loading then wraps back to the almost-empty offset.
- R10: Partial reset (`prst_n` low) empties the buffer (`empty`=1, `rd_data`=0) and leaves both offsets unchanged.
- R11: With `oe`=0, `rd_data` is high impedance.
- R12: The pointer copies sent across the clock boundary change by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low; keeps the offsets |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| oe | input | 1 | Output enable for rd_data |
| rd_data | output | DATA_W | Oldest word, high impedance when oe=0 |
| preset_sel | input | 2 | Low two bits of the preset index, sampled in master reset |
| ser_ld | input | 1 | Serial load strobe; MSB of the preset index during master reset |
| ser_en | input | 1 | Serial enable |
| ser_in | input | 1 | Serial offset data, LSB first |
| empty | output | 1 | No words held (read domain) |
| almost_empty | output | 1 | Occupancy at or below the almost-empty offset (read domain) |
| full | output | 1 | Buffer full (write domain) |
| half_full | output | 1 | More than half full (write domain) |
| almost_full | output | 1 | Free space at or below the almost-full offset (write domain) |

## Verification
The bench fills the buffer to capacity and pushes extra writes. A design that stores past full would overwrite the oldest word, and the read-back order would show it. It reads past empty and checks that `rd_data` holds its value. A broken guard would replay stale memory or move the read pointer. It shifts in twelve serial bits so that loading wraps back to the almost-empty register, then applies a partial reset. An offset register that a partial reset clears, or a load that shifts the wrong end or targets the wrong register, moves the almost-empty or almost-full edge by a word. It also selects the last preset with the serial strobe held high during master reset. Swapped index bits, or a shift that is not blocked during reset, would then give the wrong threshold pair.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

  // binary to reflected Gray code, zero-extended to 32 bits
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray code back to binary, prefix XOR from the top bit down
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 30; i >= 0; i--) b[i] = b[i + 1] ^ g[i];
    return b;
  endfunction

  // built-in threshold pairs, indexed by the three reset-time selects
  function automatic logic [31:0] preset_ae(input logic [2:0] idx);
    return 32'(idx) + 32'd1;
  endfunction

  function automatic logic [31:0] preset_af(input logic [2:0] idx);
    return 32'd8 - 32'(idx);
  endfunction

endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_offsets.sv
module fifo_offsets
  import fifo_pkg::*;
#(
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic [2:0]    sel,
  input  logic          ser_en,
  input  logic          ser_ld,
  input  logic          ser_in,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off
);
  localparam int CW = $clog2(OW) + 1;

  logic [CW-1:0] bit_cnt;
  logic          tgt_af;
  logic          shift_fire;
  logic          bit_last;

  assign shift_fire = ser_en & ser_ld;
  assign bit_last   = (bit_cnt == CW'(OW - 1));

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ae_off  <= OW'(preset_ae(sel));
      af_off  <= OW'(preset_af(sel));
      bit_cnt <= '0;
      tgt_af  <= 1'b0;
    end else if (shift_fire) begin
      if (tgt_af) af_off <= {ser_in, af_off[OW-1:1]};
      else        ae_off <= {ser_in, ae_off[OW-1:1]};
      bit_cnt <= bit_last ? '0 : bit_cnt + 1'b1;
      if (bit_last) tgt_af <= ~tgt_af;
    end
  end

  // R9
  ser_cnt_range_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    bit_cnt < CW'(OW));

  // R9
  ser_target_swap_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (shift_fire && bit_last) |=> (tgt_af != $past(tgt_af)));

  // R9
  ser_idle_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !shift_fire |=> ($stable(ae_off) && $stable(af_off)));
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] af_off,
  output logic [AW-1:0] waddr,
  output logic          wr_fire,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          half_full,
  output logic          almost_full
);
  localparam int            PW    = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);
  localparam logic [PW-1:0] HALF  = PW'(1 << (AW - 1));

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, wcount, wfree;

  assign rbin_s   = PW'(gray2bin(32'(rgray_s)));
  assign wcount   = wbin - rbin_s;
  assign wfree    = DEPTH - wcount;
  assign full     = (wcount == DEPTH);
  assign half_full   = (wcount > HALF);
  assign almost_full = (wfree <= {1'b0, af_off});
  assign wr_fire  = wr_en & ~full;
  assign wbin_nxt = wbin + PW'(wr_fire);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= PW'(bin2gray(32'(wbin_nxt)));
    end
  end

  // R3
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(wbin));

  // R3
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= DEPTH);

  // R12
  wgray_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  output logic [AW-1:0] raddr,
  output logic          rd_fire,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nxt, wbin_s, rcount;

  assign wbin_s       = PW'(gray2bin(32'(wgray_s)));
  assign rcount       = wbin_s - rbin;
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= {1'b0, ae_off});
  assign rd_fire      = rd_en & ~empty;
  assign rbin_nxt     = rbin + PW'(rd_fire);
  assign raddr        = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= PW'(bin2gray(32'(rbin_nxt)));
    end
  end

  // R4
  no_read_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> $stable(rbin));

  // R6
  empty_implies_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> almost_empty);

  // R12
  rgray_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              oe,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        preset_sel,
  input  logic              ser_ld,
  input  logic              ser_en,
  input  logic              ser_in,
  output logic              empty,
  output logic              almost_empty,
  output logic              full,
  output logic              half_full,
  output logic              almost_full
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic              rst_n;
  logic [ADDR_W-1:0] ae_off, af_off, waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  assign rst_n = mrst_n & prst_n;

  fifo_offsets #(.OW(ADDR_W)) u_offsets (
    .clk(wr_clk), .mrst_n(mrst_n), .sel({ser_ld, preset_sel}),
    .ser_en(ser_en), .ser_ld(ser_ld), .ser_in(ser_in),
    .ae_off(ae_off), .af_off(af_off)
  );

  fifo_wr_ctl #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .af_off(af_off), .waddr(waddr), .wr_fire(wr_fire), .wgray(wgray),
    .full(full), .half_full(half_full), .almost_full(almost_full)
  );

  fifo_rd_ctl #(.AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .ae_off(ae_off), .raddr(raddr), .rd_fire(rd_fire), .rgray(rgray),
    .empty(empty), .almost_empty(almost_empty)
  );

  fifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
  fifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_fire) rd_q <= mem[raddr];
  end

  assign rd_data = oe ? rd_q : 'z;

  // R2
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_q));
endmodule

// File: tb/test_dc_flag_fifo.sv
`timescale 1ns/1ps
module test_dc_flag_fifo;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0;
  logic mrst_n = 0, prst_n = 1;
  logic wr_en = 0, rd_en = 0, oe = 1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [1:0] preset_sel = '0;
  logic ser_ld = 0, ser_en = 0, ser_in = 0;
  logic empty, almost_empty, full, half_full, almost_full;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dc_flag_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_dc_flag_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .oe(oe), .rd_data(rd_data),
    .preset_sel(preset_sel), .ser_ld(ser_ld), .ser_en(ser_en), .ser_in(ser_in),
    .empty(empty), .almost_empty(almost_empty), .full(full),
    .half_full(half_full), .almost_full(almost_full)
  );

  int total = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] model[$];
  logic [DW-1:0] last_rd = '0;
  logic [DW-1:0] next_val = 16'hA001;
  int ae_exp = 1, af_exp = 8;

  // step table: bit5 = write (1) / read (0), bits4:0 = word count
  localparam logic [5:0] STEPS [7] = '{
    {1'b1, 5'd3}, {1'b0, 5'd1}, {1'b1, 5'd10}, {1'b1, 5'd6},
    {1'b0, 5'd16}, {1'b0, 5'd2}, {1'b1, 5'd9}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
  endtask

  task automatic do_write();
    @(negedge wr_clk);
    wr_en = 1; wr_data = next_val;
    @(negedge wr_clk);
    wr_en = 0;
    if (model.size() < DEPTH) model.push_back(next_val);
    next_val++;
  endtask

  task automatic do_read();
    logic [DW-1:0] e;
    @(negedge rd_clk);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    if (model.size() > 0) begin
      e = model.pop_front();
      chk("R2 read order", 32'(rd_data), 32'(e));
      last_rd = e;
    end else begin
      chk("R4 read while empty holds data", 32'(rd_data), 32'(last_rd));
    end
  endtask

  task automatic writes(input int n);
    for (int i = 0; i < n; i++) do_write();
    settle();
  endtask

  task automatic check_flags(input string tag);
    int c;
    c = model.size();
    chk({tag, " R3 full"}, 32'(full), 32'(c == DEPTH));
    chk({tag, " R6 empty"}, 32'(empty), 32'(c == 0));
    chk({tag, " R5 half_full"}, 32'(half_full), 32'(c > DEPTH / 2));
    chk({tag, " R6 almost_empty"}, 32'(almost_empty), 32'(c <= ae_exp));
    chk({tag, " R7 almost_full"}, 32'(almost_full), 32'((DEPTH - c) <= af_exp));
  endtask

  task automatic master_reset(input logic [1:0] sel, input logic ld);
    @(negedge wr_clk);
    mrst_n = 0; preset_sel = sel; ser_ld = ld;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    mrst_n = 1; ser_ld = 0;
    model.delete(); last_rd = '0;
    settle();
  endtask

  task automatic partial_reset();
    @(negedge wr_clk);
    prst_n = 0;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    prst_n = 1;
    model.delete(); last_rd = '0;
    settle();
  endtask

  task automatic serial_bits(input logic [11:0] bits);
    for (int i = 0; i < 12; i++) begin
      @(negedge wr_clk);
      ser_en = 1; ser_ld = 1; ser_in = bits[i];
    end
    @(negedge wr_clk);
    ser_en = 0; ser_ld = 0; ser_in = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // initial master reset, preset index 0: offsets 1 and 8
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    mrst_n = 1;
    settle();
    chk("R1 empty", 32'(empty), 1);
    chk("R1 almost_empty", 32'(almost_empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 half_full", 32'(half_full), 0);
    chk("R1 almost_full", 32'(almost_full), 0);
    chk("R1 rd_data", 32'(rd_data), 0);

    // table walk
    for (int s = 0; s < 7; s++) begin
      for (int k = 0; k < int'(STEPS[s][4:0]); k++) begin
        if (STEPS[s][5]) do_write();
        else do_read();
      end
      settle();
      check_flags($sformatf("step%0d", s));
    end

    // R10 partial reset with 9 held
    partial_reset();
    check_flags("R10 after partial reset");
    chk("R10 rd_data cleared", 32'(rd_data), 0);

    // R9 serial: ae=5, af=3, then wrap to ae=2
    serial_bits({4'b0010, 4'b0011, 4'b0101});
    ae_exp = 2; af_exp = 3;
    settle();
    writes(2);  check_flags("R9 ae edge in");
    writes(1);  check_flags("R9 ae edge out");
    writes(9);  check_flags("R9 af edge out");
    writes(1);  check_flags("R9 af edge in");

    // R10 offsets kept across partial reset
    partial_reset();
    writes(2);  check_flags("R10 kept ae in");
    writes(1);  check_flags("R10 kept ae out");

    // R8 preset index 7 via ser_ld high during master reset: offsets 8 and 1
    master_reset(2'b11, 1'b1);
    ae_exp = 8; af_exp = 1;
    check_flags("R1 R8 after reset");
    chk("R1 rd_data after master reset", 32'(rd_data), 0);
    writes(8);  check_flags("R8 ae at 8");
    writes(1);  check_flags("R8 ae past 8");
    writes(6);  check_flags("R8 af at 15");
    writes(1);  check_flags("R3 full at 16");
    writes(2);  check_flags("R3 writes while full dropped");
    for (int k = 0; k < DEPTH; k++) do_read();
    settle();
    check_flags("R3 drained");
    do_read();

    // R11 output enable low releases the bus
    oe = 0;
    #1;
    chk("R11 oe low bus released", 32'((rd_data === 'z) || (rd_data === '0)), 1);
    oe = 1;
    #1;
    chk("R11 oe high drives data", 32'(rd_data), 32'(last_rd));

    done = 1;
    summary();
    $finish;
  end
endmodule